// File: doc/BRIEF.md
# Burst-mode bit error qualifier

This block judges a gated serial bit stream one burst at a time. While the gate input is low a burst is in progress. The block first aligns its reference pattern to the received bits. In PRBS mode it takes the first bits of the burst as the generator seed and confirms the seed on the bits that follow. In stored-pattern mode it hunts for a 48-bit detect word taken from the stored pattern. After alignment it compares every qualified bit against the reference and keeps per-burst tallies of bits and errors.

When the gate goes high the burst is closed and given a verdict. A burst is bad if alignment never succeeded, or if its error ratio exceeds a threshold. The threshold check uses a shift and a multiply, so no divider is needed. The tallies of a good burst are folded into 32-bit running counters. The tallies of a bad burst are dropped, and only the burst and bad-burst counters advance. A one-cycle pulse with a good/bad flag reports each verdict.

Top module: `burst_ber_qualifier`

## Requirements
- R1: In PRBS mode (mode_pat=0) the reference follows x^7+x^6+1, so each bit is the XOR of the bits 7 and 6 positions earlier. The first 7 qualified bits of a burst seed it, and the next 16 are checked against it. Any mismatch among those 16 makes the burst bad and leaves all bit and error counters unchanged.
- R2: After PRBS alignment each payload bit is compared with the predicted bit. The generator advances on its own prediction, so one flipped received bit counts as exactly one error.
- R3: In stored-pattern mode (mode_pat=1) pat_word bit i is the i-th bit in line order. The detect word is pat_word bits 0 to 47. Once the last 48 qualified bits equal it, the following bits are compared with pat_word bit 48 onward, wrapping modulo PAT_LEN. The detect-word bits themselves are not counted.
- R4: In stored-pattern mode, a burst that ends before the detect word is seen is bad, and all bit and error counters stay unchanged.
- R5: A burst opens on the first cycle the gate is low while idle, and bits in that cycle are ignored. Only bits with bit_vld high and gate low are used. Bits presented while the gate is high, or with bit_vld low, have no effect.
- R6: Every error adds to err_cnt. It also adds to err0_cnt when the expected bit was 0, or to err1_cnt when the expected bit was 1.
- R7: A burst is bad when errors·2^thr_shift > bits·thr_mult. Equality counts as good. A bad burst increments burst_cnt and bad_cnt and discards its bit and error tallies.
- R8: A good burst increments burst_cnt, leaves bad_cnt alone, and adds its bit, error, errored-0 and errored-1 tallies to the running counters.
- R9: `done` is high for exactly one cycle, in the cycle after the edge that sampled the gate high during a burst. `good` carries the verdict in that cycle.
- R10: `clr` zeroes all six counters at the next edge. If a verdict falls on the same edge, the clear wins, but `done` and `good` still report the verdict.
- R11: Per-burst tallies saturate at 2^BW-1, and the running counters saturate at 2^CW-1.
- R12: After reset every counter is zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all counters |
| gate | input | 1 | Low while a burst is analysed; high ends it |
| bit_vld | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Received serial bit |
| mode_pat | input | 1 | 0 = PRBS mode, 1 = stored-pattern mode |
| pat_word | input | PAT_LEN | Stored pattern, bit 0 sent first |
| thr_shift | input | KW | Threshold exponent k |
| thr_mult | input | TW | Threshold multiplier T |
| done | output | 1 | One-cycle verdict pulse |
| good | output | 1 | Verdict of the last burst |
| burst_cnt | output | CW | Total bursts |
| bad_cnt | output | CW | Bad bursts |
| bit_cnt | output | CW | Bits counted in good bursts |
| err_cnt | output | CW | Errors counted in good bursts |
| err0_cnt | output | CW | Errors where a 0 was expected |
| err1_cnt | output | CW | Errors where a 1 was expected |

## Verification
The end-of-burst merge into the running counters and the synchronous clear can land on the same clock edge. The bench provokes this by raising `clr` in the very cycle it raises the gate to close a clean burst. It then expects `done` and `good=1` in the next cycle with all six counters at zero, and continues the following bursts from that zero base. Separate vectors place the error ratio exactly on the threshold and one step past it, to pin down the strict comparison.

// File: rtl/burst_ber_qualifier.sv
module burst_ber_qualifier #(
  parameter int PAT_LEN = 64,
  parameter int DW      = 48,
  parameter int VERIFY  = 16,
  parameter int BW      = 24,
  parameter int CW      = 32,
  parameter int KW      = 5,
  parameter int TW      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               gate,
  input  logic               bit_vld,
  input  logic               bit_in,
  input  logic               mode_pat,
  input  logic [PAT_LEN-1:0] pat_word,
  input  logic [KW-1:0]      thr_shift,
  input  logic [TW-1:0]      thr_mult,
  output logic               done,
  output logic               good,
  output logic [CW-1:0]      burst_cnt,
  output logic [CW-1:0]      bad_cnt,
  output logic [CW-1:0]      bit_cnt,
  output logic [CW-1:0]      err_cnt,
  output logic [CW-1:0]      err0_cnt,
  output logic [CW-1:0]      err1_cnt
);
  localparam int SEED  = 7;
  localparam int SLAST = SEED + VERIFY - 1;
  localparam int SW    = $clog2(SLAST + 2);
  localparam int PW    = $clog2(PAT_LEN);
  localparam int MW    = BW + (1 << KW);

  typedef enum logic [1:0] {IDLE, SYNC, TRACK, FAIL} st_t;

  st_t           st;
  logic [6:0]    lfsr;
  logic [SW-1:0] scnt;
  logic [DW-1:0] sr;
  logic [PW-1:0] ptr;
  logic [BW-1:0] tb_bits, tb_err, tb_e0, tb_e1;

  function automatic logic [BW-1:0] binc(input logic [BW-1:0] v);
    binc = (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] cadd(input logic [CW-1:0] a, input logic [BW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + (CW+1)'(b);
    cadd = s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  wire           take     = bit_vld & ~gate;
  wire           prbs_nx  = lfsr[6] ^ lfsr[5];
  wire           exp_bit  = mode_pat ? pat_word[ptr] : prbs_nx;
  wire           mis      = bit_in ^ exp_bit;
  wire [DW-1:0]  sr_nx    = {bit_in, sr[DW-1:1]};
  wire           hit      = (sr_nx == pat_word[DW-1:0]);
  wire           end_evt  = gate & (st != IDLE);
  wire [MW-1:0]  lhs      = MW'(tb_err) << thr_shift;
  wire [MW-1:0]  rhs      = MW'(tb_bits) * MW'(thr_mult);
  wire           pass     = (st == TRACK) && !(lhs > rhs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      lfsr    <= '0;
      scnt    <= '0;
      sr      <= '0;
      ptr     <= '0;
      tb_bits <= '0;
      tb_err  <= '0;
      tb_e0   <= '0;
      tb_e1   <= '0;
    end else begin
      case (st)
        IDLE: if (!gate) begin
          st      <= SYNC;
          scnt    <= '0;
          sr      <= '0;
          tb_bits <= '0;
          tb_err  <= '0;
          tb_e0   <= '0;
          tb_e1   <= '0;
        end
        SYNC: if (gate) st <= IDLE;
        else if (take) begin
          if (mode_pat) begin
            sr <= sr_nx;
            if (hit) begin
              st  <= TRACK;
              ptr <= PW'(DW % PAT_LEN);
            end
          end else if (scnt < SW'(SEED)) begin
            lfsr <= {lfsr[5:0], bit_in};
            scnt <= scnt + 1'b1;
          end else if (mis) begin
            st <= FAIL;
          end else begin
            lfsr <= {lfsr[5:0], prbs_nx};
            scnt <= scnt + 1'b1;
            if (scnt == SW'(SLAST)) st <= TRACK;
          end
        end
        TRACK: if (gate) st <= IDLE;
        else if (take) begin
          tb_bits <= binc(tb_bits);
          if (mis) begin
            tb_err <= binc(tb_err);
            if (exp_bit) tb_e1 <= binc(tb_e1);
            else         tb_e0 <= binc(tb_e0);
          end
          if (mode_pat) ptr  <= (ptr == PW'(PAT_LEN-1)) ? '0 : ptr + 1'b1;
          else          lfsr <= {lfsr[5:0], prbs_nx};
        end
        FAIL: if (gate) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      good      <= 1'b0;
      burst_cnt <= '0;
      bad_cnt   <= '0;
      bit_cnt   <= '0;
      err_cnt   <= '0;
      err0_cnt  <= '0;
      err1_cnt  <= '0;
    end else begin
      done <= end_evt;
      if (end_evt) good <= pass;
      if (clr) begin
        burst_cnt <= '0;
        bad_cnt   <= '0;
        bit_cnt   <= '0;
        err_cnt   <= '0;
        err0_cnt  <= '0;
        err1_cnt  <= '0;
      end else if (end_evt) begin
        burst_cnt <= cadd(burst_cnt, BW'(1));
        if (pass) begin
          bit_cnt  <= cadd(bit_cnt, tb_bits);
          err_cnt  <= cadd(err_cnt, tb_err);
          err0_cnt <= cadd(err0_cnt, tb_e0);
          err1_cnt <= cadd(err1_cnt, tb_e1);
        end else begin
          bad_cnt <= cadd(bad_cnt, BW'(1));
        end
      end
    end
  end
endmodule

// File: rtl/burst_ber_qualifier_chk.sv
module burst_ber_qualifier_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          done,
  input logic          good,
  input logic [CW-1:0] burst_cnt,
  input logic [CW-1:0] bad_cnt,
  input logic [CW-1:0] bit_cnt,
  input logic [CW-1:0] err_cnt,
  input logic [CW-1:0] err0_cnt,
  input logic [CW-1:0] err1_cnt
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_bad_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !good && !$past(clr) && $past(bad_cnt) != {CW{1'b1}})
      |-> bad_cnt == $past(bad_cnt) + 1'b1);

  a_r1_bad_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !good && !$past(clr))
      |-> (bit_cnt == $past(bit_cnt) && err_cnt == $past(err_cnt)));

  a_r8_burst_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(clr) && $past(burst_cnt) != {CW{1'b1}})
      |-> burst_cnt == $past(burst_cnt) + 1'b1);

  a_r8_good_keeps_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (done && good && !$past(clr)) |-> bad_cnt == $past(bad_cnt));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (burst_cnt == '0 && bad_cnt == '0 && bit_cnt == '0 &&
             err_cnt == '0 && err0_cnt == '0 && err1_cnt == '0));
endmodule

bind burst_ber_qualifier burst_ber_qualifier_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .good(good),
  .burst_cnt(burst_cnt), .bad_cnt(bad_cnt), .bit_cnt(bit_cnt),
  .err_cnt(err_cnt), .err0_cnt(err0_cnt), .err1_cnt(err1_cnt)
);

// File: tb/test_burst_ber_qualifier.sv
`timescale 1ns/1ps
module test_burst_ber_qualifier;
  localparam int CW = 32;
  localparam int BW = 10;
  localparam int MAXT = (1 << BW) - 1;
  localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;

  typedef struct packed {
    logic        mode;
    logic        fault;
    logic        gap;
    logic [11:0] nbits;
    logic [7:0]  ee;
    logic [4:0]  k;
    logic [15:0] t;
    logic        good;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 12'd100, 8'd0,  5'd0,  16'd0,  1'b1},
    '{1'b0, 1'b0, 1'b0, 12'd256, 8'd64, 5'd10, 16'd16, 1'b1},
    '{1'b0, 1'b0, 1'b0, 12'd256, 8'd64, 5'd10, 16'd15, 1'b0},
    '{1'b0, 1'b1, 1'b0, 12'd50,  8'd0,  5'd0,  16'd0,  1'b0},
    '{1'b1, 1'b0, 1'b0, 12'd120, 8'd0,  5'd0,  16'd0,  1'b1},
    '{1'b1, 1'b0, 1'b0, 12'd200, 8'd10, 5'd4,  16'd1,  1'b0},
    '{1'b1, 1'b0, 1'b0, 12'd200, 8'd10, 5'd4,  16'd2,  1'b1},
    '{1'b1, 1'b1, 1'b0, 12'd10,  8'd0,  5'd0,  16'd0,  1'b0},
    '{1'b0, 1'b0, 1'b1, 12'd60,  8'd7,  5'd0,  16'd1,  1'b1},
    '{1'b1, 1'b0, 1'b1, 12'd60,  8'd5,  5'd0,  16'd1,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, gate = 1'b1;
  logic bit_vld = 1'b0, bit_in = 1'b0, mode_pat = 1'b0;
  logic [4:0] thr_shift = '0;
  logic [15:0] thr_mult = '0;
  logic done, good;
  logic [CW-1:0] burst_cnt, bad_cnt, bit_cnt, err_cnt, err0_cnt, err1_cnt;

  always #2 clk = ~clk;

  burst_ber_qualifier #(.BW(BW)) i_burst_ber_qualifier (
    .clk(clk), .rst_n(rst_n), .clr(clr), .gate(gate), .bit_vld(bit_vld),
    .bit_in(bit_in), .mode_pat(mode_pat), .pat_word(PAT),
    .thr_shift(thr_shift), .thr_mult(thr_mult), .done(done), .good(good),
    .burst_cnt(burst_cnt), .bad_cnt(bad_cnt), .bit_cnt(bit_cnt),
    .err_cnt(err_cnt), .err0_cnt(err0_cnt), .err1_cnt(err1_cnt)
  );

  logic seq [127];
  int checks = 0, fails = 0;
  logic [31:0] m_burst = 0, m_bad = 0, m_bits = 0, m_err = 0, m_e0 = 0, m_e1 = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic b, input logic gap);
    @(negedge clk);
    bit_in = b;
    bit_vld = 1'b1;
    if (gap) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in = ~b;
    end
  endtask

  task automatic check_all(input string tag, input logic exp_good);
    chk("R9", "done pulse", {31'd0, done}, 32'd1);
    chk(exp_good ? "R8" : "R7", "good flag", {31'd0, good}, {31'd0, exp_good});
    chk("R8", "burst_cnt", burst_cnt, m_burst);
    chk("R7", "bad_cnt", bad_cnt, m_bad);
    chk(tag, "bit_cnt", bit_cnt, m_bits);
    chk(tag, "err_cnt", err_cnt, m_err);
    chk("R6", "err0_cnt", err0_cnt, m_e0);
    chk("R6", "err1_cnt", err1_cnt, m_e1);
  endtask

  task automatic burst(input string tag, input logic mode, input logic fault, input logic gap,
                       input int nbits, input int ee, input logic [4:0] k, input logic [15:0] t,
                       input logic exp_good, input logic clr_end, input int ofs);
    int tb, te, t0, t1;
    logic e, flip;
    tb = 0; te = 0; t0 = 0; t1 = 0;
    @(negedge clk);
    mode_pat = mode; thr_shift = k; thr_mult = t;
    gate = 1'b0; bit_vld = 1'b1; bit_in = 1'b1;
    if (!mode) begin
      for (int j = 0; j < 23; j++) put(seq[(ofs + j) % 127] ^ (fault && j == 12), gap);
    end else begin
      put(1'b1, gap); put(1'b0, gap); put(1'b1, gap);
      for (int j = 0; j < 48; j++) put(PAT[j] ^ (fault && j == 20), gap);
    end
    for (int i = 0; i < nbits; i++) begin
      e = mode ? PAT[(48 + i) % 64] : seq[(ofs + 23 + i) % 127];
      flip = (ee != 0) && ((i % ee) == ee - 1);
      put(e ^ flip, gap);
      if (tb < MAXT) tb++;
      if (flip) begin
        if (te < MAXT) te++;
        if (e) begin if (t1 < MAXT) t1++; end
        else   begin if (t0 < MAXT) t0++; end
      end
    end
    @(negedge clk);
    gate = 1'b1; bit_vld = 1'b1; bit_in = 1'b0; clr = clr_end;
    @(negedge clk);
    bit_vld = 1'b0; clr = 1'b0;
    if (clr_end) begin
      m_burst = 0; m_bad = 0; m_bits = 0; m_err = 0; m_e0 = 0; m_e1 = 0;
    end else begin
      m_burst++;
      if (exp_good) begin
        m_bits += tb; m_err += te; m_e0 += t0; m_e1 += t1;
      end else m_bad++;
    end
    check_all(tag, exp_good);
    @(negedge clk);
    chk("R9", "done after pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int n = 0; n < 7; n++) seq[n] = (7'b1011001 >> n) & 1'b1;
    for (int n = 7; n < 127; n++) seq[n] = seq[n-7] ^ seq[n-6];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "done after reset", {31'd0, done}, 32'd0);
    chk("R12", "burst_cnt after reset", burst_cnt, 32'd0);
    chk("R12", "bit_cnt after reset", bit_cnt, 32'd0);
    chk("R12", "err_cnt after reset", err_cnt, 32'd0);
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (VECS[v].gap) tag = "R5";
      else if (VECS[v].mode) tag = VECS[v].fault ? "R4" : "R3";
      else tag = VECS[v].fault ? "R1" : "R2";
      burst(tag, VECS[v].mode, VECS[v].fault, VECS[v].gap, int'(VECS[v].nbits),
            int'(VECS[v].ee), VECS[v].k, VECS[v].t, VECS[v].good, 1'b0, v * 13);
    end
    burst("R11", 1'b0, 1'b0, 1'b0, 1100, 0, 5'd0, 16'd0, 1'b1, 1'b0, 5);
    burst("R10", 1'b0, 1'b0, 1'b0, 30, 0, 5'd0, 16'd0, 1'b1, 1'b1, 40);
    burst("R10", 1'b1, 1'b0, 1'b0, 70, 9, 5'd0, 16'd1, 1'b1, 1'b0, 0);
    report();
  end
endmodule